// File: doc/BRIEF.md
# Sequencer Handshake Control Register

This block is the one control and status word shared by a host processor and the small microsequencer inside an arithmetic coprocessor. The host uses it to hold the sequencer in reset or release it, and to raise software trigger flags that the sequencer firmware polls. The sequencer uses it to publish a status byte and to acknowledge triggers by clearing them. The two sides have opposite rights over the trigger byte: the host can only raise a flag and the sequencer can only drop one.

The reset bit also decides which memory the host bus may reach. While the sequencer is held in reset in the program-RAM configuration, the host sees program memory so that it can load firmware, and data memory is blocked. Releasing the reset swaps the two. Status bit 8 serves as the sequencer interrupt. Its inverse is ORed into the engine's run indication, so the run output stays high until the firmware raises that bit. Starting a complex operation with a nonzero operation code raises trigger 0 automatically. A host attempt to change the reset bit while an operation is running is refused and latches an error flag.

Top module: `seq_handshake_reg`

## Requirements
- R1: After reset the reset bit equals the PROG_RAM parameter (1 for program RAM, 0 for program ROM), and the status byte, the trigger byte and the error flag are all 0.
- R2: A host write with op_run_i low loads host_wdata_i[31] into the reset bit on the next clock, and seq_rst_o shows that bit.
- R3: prog_sel_o is high exactly when the reset bit is 1 and PROG_RAM is 1, and data_sel_o is always its complement.
- R4: The status byte, read back at bits [15:8], changes only on a sequencer status write and takes seq_status_i. Host writes to bits [15:8] have no effect.
- R5: run_o is op_run_i ORed with the inverse of status bit 8, evaluated combinationally.
- R6: A host write sets every trigger bit (bits [7:0]) whose write-data bit is 1. A host write of 0 never clears a trigger bit.
- R7: A sequencer trigger write clears every trigger bit whose data bit is 0. A sequencer write of 1 never sets a trigger bit.
- R8: fn_start_i high while fn_op_i is nonzero sets trigger bit 0 on the next clock. fn_op_i codes: 0 none, 1 CRT exponentiation, 2 and 4 exponentiation variants, 3 point add, 5 point multiply, 6 variable exponentiation, 7 modular inverse. With fn_op_i = 0 the start has no effect on the triggers.
- R9: When a host set and a sequencer clear target the same trigger bit in the same cycle, the bit ends up set.
- R10: A host write with op_run_i high whose bit 31 differs from the current reset bit leaves the reset bit unchanged and sets err_o. err_o stays set until the next reset.
- R11: host_rdata_o reads as {reset bit at 31, error at 30, zeros at [29:16], status at [15:8], triggers at [7:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe for the register |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Register read value |
| seq_status_we_i | input | 1 | Sequencer status byte write strobe |
| seq_status_i | input | 8 | Sequencer status byte |
| seq_trig_we_i | input | 1 | Sequencer trigger byte write strobe |
| seq_trig_wdata_i | input | 8 | Sequencer trigger data (0 clears) |
| fn_start_i | input | 1 | Host starts an operation this cycle |
| fn_op_i | input | 3 | Complex operation code that accompanies the start |
| op_run_i | input | 1 | An operation is in progress |
| seq_rst_o | output | 1 | Holds the sequencer in reset |
| prog_sel_o | output | 1 | Host bus reaches program memory |
| data_sel_o | output | 1 | Host bus reaches data memory |
| trig_o | output | 8 | Trigger flags to the sequencer |
| run_o | output | 1 | Combined run indication |
| err_o | output | 1 | Sticky refused-reset-write error |

## Verification
Every register in this block is visible on host_rdata_o one clock after the write that changes it. A bad set or clear rule in the trigger byte, a status byte that drifts, or a reset bit that moves while an operation runs therefore shows up at the next sample. A wrong status bit 8 shows up at once on run_o. Because it steers the memory selects, a wrong reset bit is also visible on prog_sel_o and data_sel_o in that same cycle.

// File: rtl/seq_handshake_pkg.sv
package seq_handshake_pkg;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_EXP_CRT  = 3'd1,
    OP_EXP_V4   = 3'd2,
    OP_PT_ADD   = 3'd3,
    OP_EXP_V2   = 3'd4,
    OP_PT_MUL   = 3'd5,
    OP_EXP_VAR  = 3'd6,
    OP_MOD_INV  = 3'd7
  } seq_op_e;

endpackage

// File: rtl/seq_rst_ctrl.sv
module seq_rst_ctrl #(
  parameter bit PROG_RAM = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic busy_i,
  output logic rst_bit_o,
  output logic err_o
);

  logic rst_q, err_q;
  logic refuse;

  assign refuse = wr_i && busy_i && (wbit_i != rst_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= PROG_RAM;
      err_q <= 1'b0;
    end else begin
      if (wr_i && !busy_i) rst_q <= wbit_i;
      if (refuse)          err_q <= 1'b1;
    end
  end

  assign rst_bit_o = rst_q;
  assign err_o     = err_q;

endmodule

// File: rtl/seq_status_reg.sv
module seq_status_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

endmodule

// File: rtl/seq_trig_bank.sv
module seq_trig_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q;
    // set beats clear when both land together
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign q_o[i] = q;
  end

endmodule

// File: rtl/seq_handshake_reg.sv
module seq_handshake_reg
  import seq_handshake_pkg::*;
#(
  parameter bit PROG_RAM = 1'b1,
  parameter int DATA_W   = 32,
  parameter int TRIG_W   = 8,
  parameter int STAT_W   = 8,
  parameter int OP_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              seq_status_we_i,
  input  logic [STAT_W-1:0] seq_status_i,
  input  logic              seq_trig_we_i,
  input  logic [TRIG_W-1:0] seq_trig_wdata_i,
  input  logic              fn_start_i,
  input  logic [OP_W-1:0]   fn_op_i,
  input  logic              op_run_i,
  output logic              seq_rst_o,
  output logic              prog_sel_o,
  output logic              data_sel_o,
  output logic [TRIG_W-1:0] trig_o,
  output logic              run_o,
  output logic              err_o
);

  localparam int RST_POS  = DATA_W - 1;
  localparam int ERR_POS  = DATA_W - 2;
  localparam int STAT_LSB = TRIG_W;

  logic              rst_bit;
  logic [STAT_W-1:0] stat_q;
  logic [TRIG_W-1:0] trig_set, trig_clr;
  seq_op_e           op;
  logic              auto_trig;
  logic              unused_wdata;

  assign unused_wdata = ^host_wdata_i;

  seq_rst_ctrl #(.PROG_RAM(PROG_RAM)) u_rst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (host_wr_i),
    .wbit_i    (host_wdata_i[RST_POS]),
    .busy_i    (op_run_i),
    .rst_bit_o (rst_bit),
    .err_o     (err_o)
  );

  seq_status_reg #(.W(STAT_W)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (seq_status_we_i),
    .d_i    (seq_status_i),
    .q_o    (stat_q)
  );

  assign op        = seq_op_e'(fn_op_i);
  assign auto_trig = fn_start_i && (op != OP_NONE);

  always_comb begin
    trig_set    = host_wr_i ? host_wdata_i[TRIG_W-1:0] : '0;
    trig_set[0] = trig_set[0] | auto_trig;
    trig_clr    = seq_trig_we_i ? ~seq_trig_wdata_i : '0;
  end

  seq_trig_bank #(.W(TRIG_W)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (trig_set),
    .clr_i  (trig_clr),
    .q_o    (trig_o)
  );

  assign seq_rst_o  = rst_bit;
  assign prog_sel_o = PROG_RAM && rst_bit;
  assign data_sel_o = !prog_sel_o;
  assign run_o      = op_run_i | ~stat_q[0];

  always_comb begin
    host_rdata_o                          = '0;
    host_rdata_o[RST_POS]                 = rst_bit;
    host_rdata_o[ERR_POS]                 = err_o;
    host_rdata_o[STAT_LSB +: STAT_W]      = stat_q;
    host_rdata_o[TRIG_W-1:0]              = trig_o;
  end

endmodule

// File: rtl/seq_handshake_chk.sv
module seq_handshake_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        host_wr_i,
  input logic [31:0] host_wdata_i,
  input logic [31:0] host_rdata_o,
  input logic        seq_status_we_i,
  input logic        fn_start_i,
  input logic [2:0]  fn_op_i,
  input logic        op_run_i,
  input logic        seq_rst_o,
  input logic        prog_sel_o,
  input logic        data_sel_o,
  input logic        run_o,
  input logic        err_o
);

  // R3
  mem_sel_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_sel_o != data_sel_o);

  // R4
  stat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_status_we_i |=> $stable(host_rdata_o[15:8]));

  // R5
  run_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> (!op_run_i && host_rdata_o[8]));

  // R6
  trig_host_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i |=> ((host_rdata_o[7:0] & $past(host_wdata_i[7:0])) == $past(host_wdata_i[7:0])));

  // R7
  trig_no_seq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && !fn_start_i) |=> ((host_rdata_o[7:0] & ~$past(host_rdata_o[7:0])) == 8'h00));

  // R8
  auto_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_start_i && fn_op_i != 3'd0) |=> host_rdata_o[0]);

  // R10
  busy_rst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && op_run_i) |=> $stable(seq_rst_o));

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

endmodule

bind seq_handshake_reg seq_handshake_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .host_wr_i       (host_wr_i),
  .host_wdata_i    (host_wdata_i),
  .host_rdata_o    (host_rdata_o),
  .seq_status_we_i (seq_status_we_i),
  .fn_start_i      (fn_start_i),
  .fn_op_i         (fn_op_i),
  .op_run_i        (op_run_i),
  .seq_rst_o       (seq_rst_o),
  .prog_sel_o      (prog_sel_o),
  .data_sel_o      (data_sel_o),
  .run_o           (run_o),
  .err_o           (err_o)
);

// File: tb/seq_handshake_reg_bench.sv
`timescale 1ns/1ps
module seq_handshake_reg_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_wr_i = 1'b0;
  logic [31:0] host_wdata_i = '0;
  logic        seq_status_we_i = 1'b0;
  logic [7:0]  seq_status_i = '0;
  logic        seq_trig_we_i = 1'b0;
  logic [7:0]  seq_trig_wdata_i = '0;
  logic        fn_start_i = 1'b0;
  logic [2:0]  fn_op_i = '0;
  logic        op_run_i = 1'b0;

  logic [31:0] rdata, rdata_rom;
  logic        seq_rst, prog_sel, data_sel, run, err;
  logic        seq_rst_rom, prog_sel_rom, data_sel_rom, run_rom, err_rom;
  logic [7:0]  trig, trig_rom;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model state
  bit       m_rst;
  bit       m_err;
  bit [7:0] m_stat;
  bit [7:0] m_trig;

  always #10 clk_i = ~clk_i;

  seq_handshake_reg u_seq_handshake_reg (
    .clk_i, .rst_ni, .host_wr_i, .host_wdata_i, .host_rdata_o(rdata),
    .seq_status_we_i, .seq_status_i, .seq_trig_we_i, .seq_trig_wdata_i,
    .fn_start_i, .fn_op_i, .op_run_i,
    .seq_rst_o(seq_rst), .prog_sel_o(prog_sel), .data_sel_o(data_sel),
    .trig_o(trig), .run_o(run), .err_o(err)
  );

  seq_handshake_reg #(.PROG_RAM(1'b0)) u_rom (
    .clk_i, .rst_ni, .host_wr_i, .host_wdata_i, .host_rdata_o(rdata_rom),
    .seq_status_we_i, .seq_status_i, .seq_trig_we_i, .seq_trig_wdata_i,
    .fn_start_i, .fn_op_i, .op_run_i,
    .seq_rst_o(seq_rst_rom), .prog_sel_o(prog_sel_rom), .data_sel_o(data_sel_rom),
    .trig_o(trig_rom), .run_o(run_rom), .err_o(err_rom)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    if (host_wr_i) begin
      if (op_run_i) begin
        if (host_wdata_i[31] != m_rst) m_err = 1;
      end else m_rst = host_wdata_i[31];
    end
    if (seq_status_we_i) m_stat = seq_status_i;
    for (int i = 0; i < 8; i++) begin
      bit s, c;
      s = (host_wr_i && host_wdata_i[i]) || (i == 0 && fn_start_i && fn_op_i != 0);
      c = seq_trig_we_i && !seq_trig_wdata_i[i];
      if (s) m_trig[i] = 1;
      else if (c) m_trig[i] = 0;
    end
  endtask

  task automatic compare_all();
    chk("R11 rdata", rdata, {m_rst, m_err, 14'd0, m_stat, m_trig});
    chk("R2 seq_rst", 32'(seq_rst), 32'(m_rst));
    chk("R3 prog_sel", 32'(prog_sel), 32'(m_rst));
    chk("R3 data_sel", 32'(data_sel), 32'(!m_rst));
    chk("R5 run", 32'(run), 32'(op_run_i || !m_stat[0]));
    chk("R10 err", 32'(err), 32'(m_err));
    chk("R6 trig_o", 32'(trig), 32'(m_trig));
  endtask

  task automatic cyc();
    @(negedge clk_i);
    model_step();
    compare_all();
  endtask

  task automatic idle();
    host_wr_i = 0; seq_status_we_i = 0; seq_trig_we_i = 0; fn_start_i = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    m_rst = 1; m_err = 0; m_stat = 0; m_trig = 0;
    #35;
    // R1 reset state, both configurations
    chk("R1 rdata ram", rdata, 32'h8000_0000);
    chk("R1 rdata rom", rdata_rom, 32'h0000_0000);
    chk("R1 prog_sel rom", 32'(prog_sel_rom), 32'd0);
    chk("R1 run", 32'(run), 32'd1);
    rst_ni = 1;
    cyc();

    // R2/R3 release sequencer
    host_wr_i = 1; host_wdata_i = 32'h0000_0000;
    cyc(); idle();
    chk("R2 released", 32'(seq_rst), 32'd0);
    chk("R3 data_sel", 32'(data_sel), 32'd1);

    // R5 status bit 8 drops run
    seq_status_we_i = 1; seq_status_i = 8'h01;
    cyc(); idle();
    chk("R5 run low", 32'(run), 32'd0);
    op_run_i = 1; #1;
    chk("R5 run by op", 32'(run), 32'd1);
    op_run_i = 0;

    // R4 host cannot write status
    host_wr_i = 1; host_wdata_i = 32'h0000_AA00;
    cyc(); idle();
    chk("R4 status kept", 32'(rdata[15:8]), 32'h01);

    // R6 host set only
    host_wr_i = 1; host_wdata_i = 32'h0000_0005;
    cyc();
    host_wdata_i = 32'h0000_0000;
    cyc(); idle();
    chk("R6 trig", 32'(trig), 32'h05);

    // R7 sequencer clear only
    seq_trig_we_i = 1; seq_trig_wdata_i = 8'hFE;
    cyc();
    seq_trig_wdata_i = 8'hFF;
    cyc(); idle();
    chk("R7 trig", 32'(trig), 32'h04);

    // R8 auto trigger
    fn_start_i = 1; fn_op_i = 3'd0;
    cyc(); idle();
    chk("R8 op none", 32'(trig), 32'h04);
    fn_start_i = 1; fn_op_i = 3'd5;
    cyc(); idle();
    chk("R8 op mul", 32'(trig), 32'h05);

    // R9 collision
    host_wr_i = 1; host_wdata_i = 32'h0000_0008;
    seq_trig_we_i = 1; seq_trig_wdata_i = 8'h00;
    cyc(); idle();
    chk("R9 collide", 32'(trig), 32'h08);

    // R10 refused reset write
    op_run_i = 1; host_wr_i = 1; host_wdata_i = 32'h8000_0000;
    cyc(); idle(); op_run_i = 0;
    chk("R10 rst held", 32'(seq_rst), 32'd0);
    cyc();
    chk("R10 err sticky", 32'(err), 32'd1);

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      host_wr_i        = ($urandom % 4) == 0;
      host_wdata_i     = $urandom;
      seq_status_we_i  = ($urandom % 5) == 0;
      seq_status_i     = 8'($urandom);
      seq_trig_we_i    = ($urandom % 3) == 0;
      seq_trig_wdata_i = 8'($urandom);
      fn_start_i       = ($urandom % 6) == 0;
      fn_op_i          = 3'($urandom);
      op_run_i         = ($urandom % 2) == 0;
      cyc();
    end
    idle();
    done = 1;
    summary();
    $finish;
  end

endmodule